// File: doc/BRIEF.md
# Asynchronous Serial Port with Guarded Receive Buffer

This block is a full-duplex asynchronous serial port. An external baud generator supplies `tick`, a one-cycle pulse at sixteen times the bit rate. The port never divides the clock itself. A frame starts with a low start bit and ends with a high stop bit. Between them sit eight data bits, least significant first, or nine data bits when `mode9` is set. So a frame is 10 or 11 bit times long.

Transmit data flows in over a valid/ready handshake. A word is taken on a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` stays low for the whole frame, including its stop bit, so a producer is held off simply by waiting. A word offered while `tx_ready` is low is not taken, and the producer must keep it. The transmit-done and receive-ready flags are plain status bits. They set in hardware and clear only through their clear strobes.

The receiver looks for a falling edge on `rxd` while `rx_en` is high. It checks the start bit half a bit later, then samples each later bit at its midpoint. When the stop bit is sampled, acceptance rules decide whether the character goes into the receive buffer. A character that fails them is dropped without trace.

Top module: `uart_guarded_port`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, and `tx_done` and `rx_rdy` are 0. `txd` is 1 whenever no frame is being sent.
- R2: A taken word is sent as a 0 start bit, data bits LSB first, then a 1 stop bit. Each bit lasts 16 ticks. With `mode9`=0 the frame is 10 bits.
- R3: With `mode9`=1 when a frame starts, a ninth data bit goes between D7 and the stop bit. On transmit it is `tx_data[8]`; on receive it appears in `rx_data[8]`. With `mode9`=0, `rx_data[8]` reads 0.
- R4: `tx_ready` is 0 from the cycle after a word is taken until the stop bit ends. A `tx_valid` during that time starts no frame.
- R5: `tx_done` sets when the stop bit appears on `txd`. It stays 1 until a `tx_done_clr` pulse.
- R6: A falling edge on `rxd` starts reception only while `rx_en` is 1. With `rx_en`=0, a whole frame leaves `rx_rdy` at 0.
- R7: If `rxd` is high at the 8th tick after the falling edge, the receiver returns to idle as a false start and loads nothing. A frame that follows is still received.
- R8: An accepted character is written to `rx_data` and sets `rx_rdy`.
- R9: With `ext_mode`=0 and `rx_rdy`=1 at the stop-bit sample, the character is dropped and `rx_data` keeps its old value.
- R10: With `ext_mode`=1, a new character overwrites `rx_data` even while `rx_rdy` is 1.
- R11: With `frame_chk`=1, a character whose stop bit samples 0 is dropped. With `frame_chk`=0, it is accepted.
- R12: `rx_rdy` stays 1 until a `rx_rdy_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversample pulse, 16 per bit time |
| mode9 | input | 1 | Nine data bits per frame when 1 |
| ext_mode | input | 1 | Allow overwrite of an unread character |
| frame_chk | input | 1 | Drop characters whose stop bit is 0 |
| rx_en | input | 1 | Receive enable |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter can take a word |
| tx_data | input | 9 | Transmit word; bit 8 is used only in nine-bit mode |
| txd | output | 1 | Serial transmit line |
| tx_done | output | 1 | Transmit-done flag |
| tx_done_clr | input | 1 | Clears `tx_done` |
| rxd | input | 1 | Serial receive line |
| rx_rdy | output | 1 | Receive-ready flag |
| rx_rdy_clr | input | 1 | Clears `rx_rdy` |
| rx_data | output | 9 | Receive buffer |

## Verification
The hardest case to reach is a dropped character. The only trace it leaves is that nothing changes at the ports. The stimulus first loads a known character and leaves `rx_rdy` set. It then sends a second frame with a different value, either with `ext_mode` off or, after a clear, with a zero stop bit and `frame_chk` on. At the end of that frame the buffer must still hold the first value. Each drop case is followed by a case that accepts under the opposite setting, so a design that drops everything is caught too.

// File: rtl/uart_gp_pkg.sv
package uart_gp_pkg;
  typedef enum logic [1:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_STOP
  } rx_state_t;
endpackage

// File: rtl/uart_gp_tx.sv
module uart_gp_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [DATA_W:0]   ld_data,
  input  logic              mode9,
  output logic              txd,
  output logic              stop_begin
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OVS);
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [BIT_W-1:0]   bit_idx;
  logic [BIT_W-1:0]   stop_idx;
  logic [CNT_W-1:0]   ovs;
  logic               busy;
  logic               wide_q;
  logic               bit_end;

  // index of the stop bit within the frame
  assign stop_idx = wide_q ? BIT_W'(FRAME_W - 1) : BIT_W'(FRAME_W - 2);
  assign bit_end  = busy && tick && (ovs == CNT_W'(OVS - 1));
  assign ld_ready = !busy;
  assign txd      = busy ? sh[0] : 1'b1;
  assign stop_begin = bit_end && (bit_idx == stop_idx - BIT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      bit_idx <= '0;
      ovs     <= '0;
      busy    <= 1'b0;
      wide_q  <= 1'b0;
    end else if (ld_valid && !busy) begin
      // in 8-bit mode the slot after D7 already carries the stop level
      sh      <= mode9 ? {1'b1, ld_data[DATA_W], ld_data[DATA_W-1:0], 1'b0}
                       : {1'b1, 1'b1, ld_data[DATA_W-1:0], 1'b0};
      bit_idx <= '0;
      ovs     <= '0;
      busy    <= 1'b1;
      wide_q  <= mode9;
    end else if (busy && tick) begin
      if (bit_end) begin
        ovs <= '0;
        if (bit_idx == stop_idx) begin
          busy <= 1'b0;
        end else begin
          sh      <= {1'b1, sh[FRAME_W-1:1]};
          bit_idx <= bit_idx + BIT_W'(1);
        end
      end else begin
        ovs <= ovs + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_gp_rx.sv
module uart_gp_rx
  import uart_gp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              mode9,
  output logic              frame_end,
  output logic              stop_val,
  output logic [DATA_W:0]   word
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam int MID   = OVS / 2;

  rx_state_t        st;
  logic [2:0]       syn;
  logic             line;
  logic             fall;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] nbit;
  logic [BIT_W-1:0] nlast;
  logic [DATA_W:0]  sh;
  logic             wide_q;
  logic             cnt_full;

  assign line     = syn[1];
  assign fall     = syn[2] && !syn[1];
  assign nlast    = wide_q ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  assign cnt_full = (cnt == CNT_W'(OVS - 1));
  assign word     = wide_q ? sh : {1'b0, sh[DATA_W:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn       <= '1;
      st        <= RXS_IDLE;
      cnt       <= '0;
      nbit      <= '0;
      sh        <= '0;
      wide_q    <= 1'b0;
      frame_end <= 1'b0;
      stop_val  <= 1'b0;
    end else begin
      syn       <= {syn[1:0], rxd};
      frame_end <= 1'b0;
      unique case (st)
        RXS_IDLE: begin
          if (rx_en && fall) begin
            st  <= RXS_START;
            cnt <= '0;
          end
        end
        RXS_START: begin
          if (tick) begin
            if (cnt == CNT_W'(MID - 1)) begin
              cnt <= '0;
              if (line) begin
                st <= RXS_IDLE;
              end else begin
                st     <= RXS_DATA;
                nbit   <= '0;
                wide_q <= mode9;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        RXS_DATA: begin
          if (tick) begin
            if (cnt_full) begin
              cnt <= '0;
              sh  <= {line, sh[DATA_W:1]};
              if (nbit == nlast) st <= RXS_STOP;
              else nbit <= nbit + BIT_W'(1);
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        RXS_STOP: begin
          if (tick) begin
            if (cnt_full) begin
              cnt       <= '0;
              st        <= RXS_IDLE;
              frame_end <= 1'b1;
              stop_val  <= line;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: st <= RXS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_gp_rxbuf.sv
module uart_gp_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              stop_val,
  input  logic [DATA_W:0]   word,
  input  logic              ext_mode,
  input  logic              frame_chk,
  input  logic              clr,
  output logic              full,
  output logic [DATA_W:0]   buf_q
);
  logic room_ok;
  logic stop_ok;
  logic take;

  assign room_ok = ext_mode || !full;
  assign stop_ok = !frame_chk || stop_val;
  assign take    = frame_end && room_ok && stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      buf_q <= '0;
    end else if (take) begin
      full  <= 1'b1;
      buf_q <= word;
    end else if (clr) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_guarded_port.sv
module uart_guarded_port #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode9,
  input  logic              ext_mode,
  input  logic              frame_chk,
  input  logic              rx_en,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W:0]   tx_data,
  output logic              txd,
  output logic              tx_done,
  input  logic              tx_done_clr,
  input  logic              rxd,
  output logic              rx_rdy,
  input  logic              rx_rdy_clr,
  output logic [DATA_W:0]   rx_data
);
  logic            stop_begin;
  logic            frame_end;
  logic            stop_val;
  logic [DATA_W:0] rx_word;

  uart_gp_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ld_valid   (tx_valid),
    .ld_ready   (tx_ready),
    .ld_data    (tx_data),
    .mode9      (mode9),
    .txd        (txd),
    .stop_begin (stop_begin)
  );

  uart_gp_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rxd       (rxd),
    .rx_en     (rx_en),
    .mode9     (mode9),
    .frame_end (frame_end),
    .stop_val  (stop_val),
    .word      (rx_word)
  );

  uart_gp_rxbuf #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .stop_val  (stop_val),
    .word      (rx_word),
    .ext_mode  (ext_mode),
    .frame_chk (frame_chk),
    .clr       (rx_rdy_clr),
    .full      (rx_rdy),
    .buf_q     (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_done <= 1'b0;
    else if (stop_begin) tx_done <= 1'b1;
    else if (tx_done_clr) tx_done <= 1'b0;
  end
endmodule

// File: rtl/uart_gp_chk.sv
module uart_gp_chk #(
  parameter int DATA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            txd,
  input logic            tx_done,
  input logic            tx_done_clr,
  input logic            rx_rdy,
  input logic            rx_rdy_clr,
  input logic            ext_mode,
  input logic [DATA_W:0] rx_data
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd); // R1
  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R4
  AST_DONE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (txd && !tx_ready)); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_done_clr) |=> tx_done); // R5
  AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && !rx_rdy_clr) |=> rx_rdy); // R12
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && !ext_mode) |=> $stable(rx_data)); // R9
endmodule

bind uart_guarded_port uart_gp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .txd         (txd),
  .tx_done     (tx_done),
  .tx_done_clr (tx_done_clr),
  .rx_rdy      (rx_rdy),
  .rx_rdy_clr  (rx_rdy_clr),
  .ext_mode    (ext_mode),
  .rx_data     (rx_data)
);

// File: tb/sim_uart_guarded_port.sv
`timescale 1ns/1ps
module sim_uart_guarded_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tdiv = 1'b0;
  logic       tick;
  logic       mode9 = 1'b0, ext_mode = 1'b0, frame_chk = 1'b0, rx_en = 1'b0;
  logic       tx_valid = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_done_clr = 1'b0, rx_rdy_clr = 1'b0;
  logic       rxd = 1'b1;
  logic       tx_ready, txd, tx_done, rx_rdy;
  logic [8:0] rx_data;

  int total = 0;
  int bad = 0;
  int frames_seen = 0;
  logic [9:0] expq[$];

  always #2 clk = ~clk;
  always @(negedge clk) tdiv <= ~tdiv;
  assign tick = tdiv;

  uart_guarded_port u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode9(mode9), .ext_mode(ext_mode),
    .frame_chk(frame_chk), .rx_en(rx_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .txd(txd), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
    .rxd(rxd), .rx_rdy(rx_rdy), .rx_rdy_clr(rx_rdy_clr), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (tick !== 1'b1) @(negedge clk);
    end
  endtask

  // driver: push the expected frame, then offer the word
  task automatic send(input logic [8:0] d, input bit m9);
    expq.push_back({m9, d});
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    mode9 = m9; tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic finish_tx(input int n);
    wait (frames_seen == n);
    wait_ticks(12);
    chk(tx_done == 1'b1, "R5 done held", tx_done, 1);
    chk(tx_ready == 1'b1, "R1 ready after frame", tx_ready, 1);
    tx_done_clr = 1'b1; @(negedge clk); tx_done_clr = 1'b0; @(negedge clk);
    chk(tx_done == 1'b0, "R5 done cleared", tx_done, 0);
  endtask

  // monitor: decode txd and compare with the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        logic [9:0] e;
        logic [8:0] got;
        int nb;
        got = '0;
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected frame", 1, 0);
          e = '0;
        end else e = expq.pop_front();
        nb = e[9] ? 9 : 8;
        wait_ticks(8);
        chk(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < nb; i++) begin
          wait_ticks(16);
          got[i] = txd;
          if (i == nb - 1) chk(tx_done == 1'b0, "R5 done early", tx_done, 0);
        end
        wait_ticks(16);
        chk(txd == 1'b1, "R2 stop bit", txd, 1);
        chk(tx_done == 1'b1, "R5 done at stop", tx_done, 1);
        if (e[9]) chk(got == e[8:0], "R3 tx nine-bit data", got, e[8:0]);
        else      chk(got[7:0] == e[7:0], "R2 tx data", got, e[7:0]);
        frames_seen++;
      end
    end
  end

  task automatic rx_frame(input logic [8:0] d, input bit m9, input bit stopv);
    @(negedge clk); while (tick !== 1'b1) @(negedge clk);
    rxd = 1'b0; wait_ticks(16);
    for (int i = 0; i < (m9 ? 9 : 8); i++) begin
      rxd = d[i]; wait_ticks(16);
    end
    rxd = stopv; wait_ticks(16);
    rxd = 1'b1; wait_ticks(4);
  endtask

  task automatic clr_rx();
    rx_rdy_clr = 1'b1; @(negedge clk); rx_rdy_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd reset", txd, 1);
    chk(tx_ready == 1'b1, "R1 ready reset", tx_ready, 1);
    chk(tx_done == 1'b0, "R1 done reset", tx_done, 0);
    chk(rx_rdy == 1'b0, "R1 rdy reset", rx_rdy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // transmit
    send(9'h0A5, 1'b0); finish_tx(1);
    send(9'h03C, 1'b0); finish_tx(2);
    send(9'h15A, 1'b1); finish_tx(3);   // R3 ninth bit 1
    send(9'h0C3, 1'b1); finish_tx(4);   // R3 ninth bit 0
    send(9'h00F, 1'b0);
    wait_ticks(20);
    chk(tx_ready == 1'b0, "R4 ready low busy", tx_ready, 0);
    tx_data = 9'h0FF; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    finish_tx(5);
    wait_ticks(40);
    chk(frames_seen == 5 && expq.size() == 0, "R4 write ignored", frames_seen, 5);
    mode9 = 1'b0;

    // receive
    rx_en = 1'b1;
    rx_frame(9'h096, 1'b0, 1'b1);
    chk(rx_rdy == 1'b1, "R8 rdy set", rx_rdy, 1);
    chk(rx_data == 9'h096, "R8 data", rx_data, 9'h096);
    repeat (200) @(negedge clk);
    chk(rx_rdy == 1'b1, "R12 rdy held", rx_rdy, 1);
    rx_frame(9'h011, 1'b0, 1'b1);
    chk(rx_data == 9'h096, "R9 unread kept", rx_data, 9'h096);
    clr_rx();
    chk(rx_rdy == 1'b0, "R12 rdy cleared", rx_rdy, 0);
    rx_frame(9'h011, 1'b0, 1'b1);
    chk(rx_data == 9'h011 && rx_rdy, "R8 data after clear", rx_data, 9'h011);
    ext_mode = 1'b1;
    rx_frame(9'h022, 1'b0, 1'b1);
    chk(rx_data == 9'h022, "R10 overwrite", rx_data, 9'h022);
    ext_mode = 1'b0; clr_rx();
    frame_chk = 1'b1;
    rx_frame(9'h033, 1'b0, 1'b0);
    chk(rx_rdy == 1'b0, "R11 bad stop dropped", rx_rdy, 0);
    chk(rx_data == 9'h022, "R11 data kept", rx_data, 9'h022);
    frame_chk = 1'b0;
    rx_frame(9'h044, 1'b0, 1'b0);
    chk(rx_rdy == 1'b1 && rx_data == 9'h044, "R11 unchecked stop", rx_data, 9'h044);
    clr_rx();
    rx_en = 1'b0;
    rx_frame(9'h055, 1'b0, 1'b1);
    chk(rx_rdy == 1'b0, "R6 disabled", rx_rdy, 0);
    rx_en = 1'b1;
    rxd = 1'b0; wait_ticks(4); rxd = 1'b1; wait_ticks(20);
    chk(rx_rdy == 1'b0, "R7 false start", rx_rdy, 0);
    rx_frame(9'h066, 1'b0, 1'b1);
    chk(rx_rdy == 1'b1 && rx_data == 9'h066, "R7 frame after glitch", rx_data, 9'h066);
    clr_rx();
    mode9 = 1'b1;
    rx_frame(9'h1C3, 1'b1, 1'b1);
    chk(rx_data == 9'h1C3, "R3 rx nine-bit", rx_data, 9'h1C3);
    mode9 = 1'b0; clr_rx();
    rx_frame(9'h0E7, 1'b0, 1'b1);
    chk(rx_data == 9'h0E7, "R3 rx bit8 zero", rx_data, 9'h0E7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule